// File: doc/BRIEF.md
# Dual-Clock Mailbox Bypass Pair

This block holds two single-word mailboxes that let one word travel between two ports without passing through the queues beside them. Port A runs on its own clock and port B on another. The forward mailbox carries a word from A to B. The return mailbox carries a word from B to A. Each port has five controls: a chip select (active low), a write/read select, an enable, a mailbox select and a data input. The write/read select has opposite polarity on the two ports.

A mailbox is loaded in its writer's clock domain and emptied in its reader's clock domain. The receiving port sees an active-low full flag for it. Each flag change crosses domains as a toggle through a two-flop synchronizer. The written word stays in the register until the next accepted write. When the mailbox select is LOW, each port's read data shows the queue word from its input instead of the mailbox. In place of tri-state pads, an output-enable tells when the port's read data is valid.

Top module: `mbx_pair`

## Requirements
- R1: After master reset, both mailbox registers read as zero and both full flags are HIGH (empty).
- R2: An accepted port A mailbox write loads the forward mailbox and drives the port B full flag LOW within three port B clock edges. An accepted write needs chip select LOW, write/read select HIGH, enable HIGH and mailbox select HIGH on a rising port A clock edge.
- R3: Port B reads the mailbox when chip select is LOW, write/read select is HIGH and mailbox select is HIGH. In that state the port B data output shows the forward mailbox word. A read with enable HIGH on a rising port B edge returns the port B full flag HIGH right after that edge.
- R4: Reading a mailbox does not clear or change its stored word.
- R5: The return direction mirrors R2 and R3. Port B writes with write/read select LOW, loads the return mailbox and drives the port A full flag LOW. Port A reads with write/read select LOW and clears that flag.
- R6: Write/read select LOW on port A, or HIGH on port B, never loads a mailbox.
- R7: A write to a mailbox that its writer still sees as full is ignored. A write accepted after the read has crossed back loads the new word.
- R8: A mailbox read while the flag is HIGH returns the last stored word and leaves the flag HIGH.
- R9: A port's output enable is HIGH only when its chip select is LOW and a read is selected.
- R10: With mailbox select LOW, a port's read data is the queue word on that port's queue input.
- R11: A mailbox write with enable LOW or chip select HIGH is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous master reset, active low |
| clk_a_i | input | 1 | Port A clock |
| cs_a_ni | input | 1 | Port A chip select, active low |
| wr_rd_a_i | input | 1 | Port A select: HIGH write, LOW read |
| en_a_i | input | 1 | Port A enable |
| mb_a_i | input | 1 | Port A mailbox select |
| data_a_i | input | WORD_W | Port A write data |
| q2_data_a_i | input | WORD_W | Queue word offered to port A reads |
| data_a_o | output | WORD_W | Port A read data |
| oe_a_o | output | 1 | Port A read data valid |
| mbx2_full_a_no | output | 1 | Return mailbox full flag, active low, port A domain |
| clk_b_i | input | 1 | Port B clock |
| cs_b_ni | input | 1 | Port B chip select, active low |
| wr_rd_b_i | input | 1 | Port B select: LOW write, HIGH read |
| en_b_i | input | 1 | Port B enable |
| mb_b_i | input | 1 | Port B mailbox select |
| data_b_i | input | WORD_W | Port B write data |
| q1_data_b_i | input | WORD_W | Queue word offered to port B reads |
| data_b_o | output | WORD_W | Port B read data |
| oe_b_o | output | 1 | Port B read data valid |
| mbx1_full_b_no | output | 1 | Forward mailbox full flag, active low, port B domain |

## Verification
Read data and output enable are combinational from the port controls and the stored words, so they are checked in the same cycle the controls are set. A read-side flag clear lands on the reading edge and is sampled at the next falling edge of that clock. A write becomes visible at the reader only after two synchronizer flops, so that port's flag is checked after four falling edges of the reader's clock, which is more than the worst-case lag. The writer's own full view returns through the opposite synchronizer, so each "write after drain" step waits four writer clock cycles before it writes again.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef struct packed {
    logic mb_wr;
    logic mb_rd;
    logic oe;
    logic sel_mb;
  } port_op_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[s] <= 1'b0;
        else if (s == 0) ff_q[s] <= d_i;
        else ff_q[s] <= ff_q[(s > 0) ? s-1 : 0];
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
  import mbx_pkg::*;
#(
  parameter bit WR_LEVEL = 1'b1
) (
  input  logic     cs_ni,
  input  logic     wr_rd_i,
  input  logic     en_i,
  input  logic     mb_i,
  output port_op_t op_o
);
  logic sel_wr;
  assign sel_wr = (wr_rd_i == WR_LEVEL);

  always_comb begin
    op_o.oe     = !cs_ni && !sel_wr;
    op_o.mb_wr  = !cs_ni && en_i && mb_i && sel_wr;
    op_o.mb_rd  = !cs_ni && en_i && mb_i && !sel_wr;
    op_o.sel_mb = mb_i;
  end
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int WORD_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              rst_ni,
  input  logic              wclk_i,
  input  logic              wr_req_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              rclk_i,
  input  logic              rd_req_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              full_n_o
);
  logic [WORD_W-1:0] data_q;
  logic wtgl_q, rtgl_q, wtgl_rs, rtgl_ws;
  logic full_w, full_r, wr_fire, rd_fire;

  // writer domain
  assign full_w  = wtgl_q ^ rtgl_ws;
  assign wr_fire = wr_req_i && !full_w;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      wtgl_q <= 1'b0;
    end else if (wr_fire) begin
      data_q <= wdata_i;
      wtgl_q <= ~wtgl_q;
    end
  end

  mbx_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rtgl_q), .q_o(rtgl_ws)
  );

  // reader domain
  mbx_sync #(.STAGES(SYNC_STAGES)) u_put_sync (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wtgl_q), .q_o(wtgl_rs)
  );

  assign full_r  = wtgl_rs ^ rtgl_q;
  assign rd_fire = rd_req_i && full_r;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) rtgl_q <= 1'b0;
    else if (rd_fire) rtgl_q <= ~rtgl_q;
  end

  // word is stable while flagged, so reader samples it directly
  assign rdata_o  = data_q;
  assign full_n_o = !full_r;

  p_write_sets_full_r2: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wr_fire |=> full_w);
  p_read_clears_flag_r3: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rd_fire |=> !full_r);
  p_word_stable_flagged_r4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (full_r && !rd_fire) |=> $stable(data_q));
  p_hold_when_full_r7: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_w |=> $stable(data_q));
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
  import mbx_pkg::*;
#(
  parameter int WORD_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              rst_ni,
  input  logic              clk_a_i,
  input  logic              cs_a_ni,
  input  logic              wr_rd_a_i,
  input  logic              en_a_i,
  input  logic              mb_a_i,
  input  logic [WORD_W-1:0] data_a_i,
  input  logic [WORD_W-1:0] q2_data_a_i,
  output logic [WORD_W-1:0] data_a_o,
  output logic              oe_a_o,
  output logic              mbx2_full_a_no,
  input  logic              clk_b_i,
  input  logic              cs_b_ni,
  input  logic              wr_rd_b_i,
  input  logic              en_b_i,
  input  logic              mb_b_i,
  input  logic [WORD_W-1:0] data_b_i,
  input  logic [WORD_W-1:0] q1_data_b_i,
  output logic [WORD_W-1:0] data_b_o,
  output logic              oe_b_o,
  output logic              mbx1_full_b_no
);
  port_op_t op_a, op_b;
  logic [WORD_W-1:0] mbx1_word, mbx2_word;

  // port A writes on HIGH, port B writes on LOW
  mbx_port_dec #(.WR_LEVEL(1'b1)) u_dec_a (
    .cs_ni(cs_a_ni), .wr_rd_i(wr_rd_a_i), .en_i(en_a_i), .mb_i(mb_a_i), .op_o(op_a)
  );
  mbx_port_dec #(.WR_LEVEL(1'b0)) u_dec_b (
    .cs_ni(cs_b_ni), .wr_rd_i(wr_rd_b_i), .en_i(en_b_i), .mb_i(mb_b_i), .op_o(op_b)
  );

  mbx_channel #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_mbx1 (
    .rst_ni(rst_ni),
    .wclk_i(clk_a_i), .wr_req_i(op_a.mb_wr), .wdata_i(data_a_i),
    .rclk_i(clk_b_i), .rd_req_i(op_b.mb_rd), .rdata_o(mbx1_word),
    .full_n_o(mbx1_full_b_no)
  );

  mbx_channel #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_mbx2 (
    .rst_ni(rst_ni),
    .wclk_i(clk_b_i), .wr_req_i(op_b.mb_wr), .wdata_i(data_b_i),
    .rclk_i(clk_a_i), .rd_req_i(op_a.mb_rd), .rdata_o(mbx2_word),
    .full_n_o(mbx2_full_a_no)
  );

  assign data_a_o = op_a.sel_mb ? mbx2_word : q2_data_a_i;
  assign oe_a_o   = op_a.oe;
  assign data_b_o = op_b.sel_mb ? mbx1_word : q1_data_b_i;
  assign oe_b_o   = op_b.oe;
endmodule

// File: tb/mbx_pair_tb.sv
module mbx_pair_tb;
  localparam int W = 36;

  logic rst_ni = 1'b0;
  logic clk_a = 1'b0, clk_b = 1'b0;
  logic cs_a_n = 1'b1, wr_rd_a = 1'b0, en_a = 1'b0, mb_a = 1'b0;
  logic cs_b_n = 1'b1, wr_rd_b = 1'b1, en_b = 1'b0, mb_b = 1'b0;
  logic [W-1:0] din_a = '0, din_b = '0, q2_a = '0, q1_b = '0;
  logic [W-1:0] dout_a, dout_b;
  logic oe_a, oe_b, full2_a_n, full1_b_n;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk_a = ~clk_a;  // 250 MHz
  always #3 clk_b = ~clk_b;

  mbx_pair #(.WORD_W(W)) u_dut (
    .rst_ni(rst_ni),
    .clk_a_i(clk_a), .cs_a_ni(cs_a_n), .wr_rd_a_i(wr_rd_a), .en_a_i(en_a), .mb_a_i(mb_a),
    .data_a_i(din_a), .q2_data_a_i(q2_a), .data_a_o(dout_a), .oe_a_o(oe_a),
    .mbx2_full_a_no(full2_a_n),
    .clk_b_i(clk_b), .cs_b_ni(cs_b_n), .wr_rd_b_i(wr_rd_b), .en_b_i(en_b), .mb_b_i(mb_b),
    .data_b_i(din_b), .q1_data_b_i(q1_b), .data_b_o(dout_b), .oe_b_o(oe_b),
    .mbx1_full_b_no(full1_b_n)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_a(input int n); repeat (n) @(negedge clk_a); endtask
  task automatic wait_b(input int n); repeat (n) @(negedge clk_b); endtask

  // one port A cycle with the given controls, then idle
  task automatic op_a(input logic cs_n, input logic wr, input logic en, input logic mb,
                      input logic [W-1:0] d);
    @(negedge clk_a);
    cs_a_n = cs_n; wr_rd_a = wr; en_a = en; mb_a = mb; din_a = d;
    @(negedge clk_a);
    cs_a_n = 1'b1; en_a = 1'b0; mb_a = 1'b0;
  endtask

  task automatic op_b(input logic cs_n, input logic wr, input logic en, input logic mb,
                      input logic [W-1:0] d);
    @(negedge clk_b);
    cs_b_n = cs_n; wr_rd_b = wr; en_b = en; mb_b = mb; din_b = d;
    @(negedge clk_b);
    cs_b_n = 1'b1; en_b = 1'b0; mb_b = 1'b0;
  endtask

  // peek mailbox through a read with enable LOW
  task automatic peek_b(output logic [W-1:0] v, output logic oe);
    @(negedge clk_b);
    cs_b_n = 1'b0; wr_rd_b = 1'b1; mb_b = 1'b1; en_b = 1'b0;
    #1; v = dout_b; oe = oe_b;
    cs_b_n = 1'b1; mb_b = 1'b0;
  endtask

  task automatic peek_a(output logic [W-1:0] v, output logic oe);
    @(negedge clk_a);
    cs_a_n = 1'b0; wr_rd_a = 1'b0; mb_a = 1'b1; en_a = 1'b0;
    #1; v = dout_a; oe = oe_a;
    cs_a_n = 1'b1; mb_a = 1'b0;
  endtask

  task automatic t_reset();
    logic [W-1:0] v; logic oe;
    chk("R1 flag_b", W'(full1_b_n), W'(1));
    chk("R1 flag_a", W'(full2_a_n), W'(1));
    peek_b(v, oe); chk("R1 mbx1 zero", v, '0);
    peek_a(v, oe); chk("R1 mbx2 zero", v, '0);
  endtask

  task automatic t_fwd_write_read();
    logic [W-1:0] v; logic oe;
    op_a(1'b0, 1'b1, 1'b1, 1'b1, 36'h9_ABCD_1234);
    wait_b(4);
    chk("R2 flag_b low", W'(full1_b_n), W'(0));
    peek_b(v, oe);
    chk("R3 data_b", v, 36'h9_ABCD_1234);
    chk("R9 oe on read", W'(oe), W'(1));
    // second write while full is dropped (R7)
    op_a(1'b0, 1'b1, 1'b1, 1'b1, 36'h1_1111_1111);
    wait_b(4);
    peek_b(v, oe);
    chk("R7 full write ignored", v, 36'h9_ABCD_1234);
    op_b(1'b0, 1'b1, 1'b1, 1'b1, '0);
    chk("R3 flag_b cleared", W'(full1_b_n), W'(1));
    peek_b(v, oe);
    chk("R4 word kept", v, 36'h9_ABCD_1234);
    op_b(1'b0, 1'b1, 1'b1, 1'b1, '0);
    peek_b(v, oe);
    chk("R8 empty read word", v, 36'h9_ABCD_1234);
    chk("R8 flag stays high", W'(full1_b_n), W'(1));
    wait_a(4);
    op_a(1'b0, 1'b1, 1'b1, 1'b1, 36'h5_0F0F_0F0F);
    wait_b(4);
    peek_b(v, oe);
    chk("R7 write after drain", v, 36'h5_0F0F_0F0F);
    op_b(1'b0, 1'b1, 1'b1, 1'b1, '0);
    wait_a(4);
  endtask

  task automatic t_polarity_and_gate();
    logic [W-1:0] v; logic oe;
    op_a(1'b0, 1'b0, 1'b1, 1'b1, 36'h7_7777_7777);  // A read, not write
    op_a(1'b1, 1'b1, 1'b1, 1'b1, 36'h6_6666_6666);  // cs high
    op_a(1'b0, 1'b1, 1'b0, 1'b1, 36'h4_4444_4444);  // enable low
    wait_b(4);
    chk("R6 A read no load flag", W'(full1_b_n), W'(1));
    chk("R11 gated write flag", W'(full1_b_n), W'(1));
    peek_b(v, oe);
    chk("R11 gated write data", v, 36'h5_0F0F_0F0F);
    op_b(1'b0, 1'b1, 1'b1, 1'b1, 36'h3_3333_3333);  // B read, not write
    wait_a(4);
    chk("R6 B read no load flag", W'(full2_a_n), W'(1));
    peek_a(v, oe);
    chk("R6 B read no load data", v, '0);
  endtask

  task automatic t_reverse();
    logic [W-1:0] v; logic oe;
    op_b(1'b0, 1'b0, 1'b1, 1'b1, 36'hC_0DE0_BEEF);
    wait_a(4);
    chk("R5 flag_a low", W'(full2_a_n), W'(0));
    peek_a(v, oe);
    chk("R5 data_a", v, 36'hC_0DE0_BEEF);
    op_a(1'b0, 1'b0, 1'b1, 1'b1, '0);
    chk("R5 flag_a cleared", W'(full2_a_n), W'(1));
    peek_a(v, oe);
    chk("R5 word kept", v, 36'hC_0DE0_BEEF);
  endtask

  task automatic t_oe_and_queue();
    @(negedge clk_b);
    cs_b_n = 1'b1; wr_rd_b = 1'b1; mb_b = 1'b1; #1;
    chk("R9 oe cs high", W'(oe_b), W'(0));
    cs_b_n = 1'b0; wr_rd_b = 1'b0; #1;
    chk("R9 oe write sel", W'(oe_b), W'(0));
    wr_rd_b = 1'b1; mb_b = 1'b0; q1_b = 36'hA_5A5A_5A5A; #1;
    chk("R10 queue word b", dout_b, 36'hA_5A5A_5A5A);
    chk("R9 oe b read", W'(oe_b), W'(1));
    cs_b_n = 1'b1;
    @(negedge clk_a);
    cs_a_n = 1'b0; wr_rd_a = 1'b0; mb_a = 1'b0; q2_a = 36'h2_2468_ACE0; #1;
    chk("R10 queue word a", dout_a, 36'h2_2468_ACE0);
    wr_rd_a = 1'b1; #1;
    chk("R9 oe a write sel", W'(oe_a), W'(0));
    cs_a_n = 1'b1;
  endtask

  initial begin
    wait_a(3);
    rst_ni = 1'b1;
    wait_b(2);
    t_reset();
    t_fwd_write_read();
    t_polarity_and_gate();
    t_reverse();
    t_oe_and_queue();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule